// File: doc/BRIEF.md
# Time-Interleaved ADC Channel Combiner

This block takes the outputs of several sub-converters that share one input signal and merges them into a single stream. Each sub-converter runs at the per-channel rate fs. Channel k samples k/NCH of a sample period after channel 0. The combined stream therefore represents NCH·fs. Every channel first gets its own offset correction, an adder with a fractional-LSB trim. It then gets its own gain correction, a multiplier. After that the channels are placed side by side in sampling-phase order. Offset and gain mismatches between channels would otherwise show up as spurs at fs and its multiples.

All NCH samples of one fs period arrive together as one packed word with a shared valid strobe. The corrected word leaves two register stages later. A serial copy presents the same word one lane per clock, earliest phase first, for logic that wants a sample-by-sample view. Coefficients are written from outside into a shadow set. They move into the working set only on a frame strobe, so all channels change at the same time.

Top module: `tiadc_combiner`

## Requirements
- R1: After a synchronous active-low reset, out_valid and ser_valid are 0 and out_data is all zeros. Every channel's working offset is 0 and its working gain is unity, so samples pass through unchanged.
- R2: Input slice k (bits k·SW upward) is channel k, the channel sampled k/NCH of a period after channel 0. It appears in the same slice of out_data, so lane 0 holds the earliest phase. With offset 0 and unity gain the output equals the input.
- R3: A word sampled with in_valid on one rising edge appears on out_data with out_valid high after the second following rising edge. Back-to-back valid words are all delivered, each exactly once.
- R4: The offset is an OFS_W-bit two's-complement value with OFB = 3 fractional bits (1/8 LSB steps). It is written from cfg_wdata[OFS_W-1:0] with cfg_sel = 0, and is added to the sample before the gain is applied: (8·x + off).
- R5: The gain is unsigned Q1.15, written from cfg_wdata[15:0] with cfg_sel = 1. 16'h8000 is unity. The corrected value is (8·x + off)·gain / 2^18.
- R6: The corrected value is rounded to nearest. Exact halves round toward plus infinity, including for negative values.
- R7: Results above 2^(SW-1)-1 or below -2^(SW-1) saturate to those limits.
- R8: A coefficient write (cfg_we with cfg_ch selecting the channel) changes nothing at the outputs until the next clock with frame_sync high. The sample captured on that same edge still uses the old set. Samples captured on later edges use the new set. A write made in the frame_sync cycle waits for the following frame_sync.
- R9: On a frame_sync edge every channel's working offset and gain are replaced together from the shadow set.
- R10: Each out_valid word is replayed on ser_data over NCH consecutive cycles from lane 0 up, with ser_lane naming the lane and ser_valid high. It starts one cycle after the word appears on out_data. A newer word restarts the replay at lane 0.
- R11: Coefficients written to channel k affect only lane k of the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the per-channel sample rate fs |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Shared strobe: the in_data word holds one sample per channel |
| in_data | input | NCH·SW (32) | Packed channel samples, channel k at bits k·SW upward |
| frame_sync | input | 1 | Frame boundary; copies the shadow coefficients into the working set |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_ch | input | log2(NCH) (2) | Channel index of the write |
| cfg_sel | input | 1 | 0 selects the offset, 1 selects the gain |
| cfg_wdata | input | 16 | Coefficient value |
| out_valid | output | 1 | out_data holds a new corrected word |
| out_data | output | NCH·SW (32) | Corrected samples in sampling-phase order |
| ser_valid | output | 1 | ser_data holds one lane of the latest word |
| ser_data | output | SW (8) | Serial view, one corrected sample per clock |
| ser_lane | output | log2(NCH) (2) | Lane index of ser_data |

## Verification
The assertions watch the following every cycle:
- the two-edge valid delay in both directions;
- that the working coefficients hold still except on a frame strobe;
- that a saturating result lands exactly on the limit;
- that the serial lane index steps by one or restarts at zero.

The arithmetic itself can only be shown by the bench's scenarios. Those scenarios cover the exact rounding of half-LSB cases, the sign handling of fractional offsets, the edge on which a commit takes effect, and that a trim on one channel leaves the other lanes alone. The bench's reference model checks each of these against hand-chosen and pseudo-random traffic.

// File: rtl/tiadc_pkg.sv
// Shared constants and types for the interleaved-converter combiner.
// Assumes gains are unsigned Q1.15 held in 16 bits.
package tiadc_pkg;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 15;
    localparam logic [GAIN_W-1:0] GAIN_UNITY = 16'h8000;

    typedef enum logic {
        SEL_OFFSET = 1'b0,
        SEL_GAIN   = 1'b1
    } coef_sel_e;
endpackage

// File: rtl/tiadc_coef_bank.sv
// Per-channel coefficient storage: a shadow set written one field at a time,
// and a working set that takes the whole shadow set on frame_sync.
// Assumes OFS_W <= GAIN_W (offsets use the low bits of the write data).
module tiadc_coef_bank
    import tiadc_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int OFS_W = 8,
    localparam int CHW  = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CHW-1:0]          cfg_ch,
    input  coef_sel_e               cfg_sel,
    input  logic [GAIN_W-1:0]       cfg_wdata,
    input  logic                    frame_sync,
    output logic [NCH*OFS_W-1:0]    act_off,
    output logic [NCH*GAIN_W-1:0]   act_gain
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [OFS_W-1:0]  sh_off_q;
        logic [GAIN_W-1:0] sh_gain_q;
        logic              hit;

        assign hit = cfg_we && (cfg_ch == CHW'(c));

        // Capture software writes into this channel's shadow fields.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_off_q  <= '0;
                sh_gain_q <= GAIN_UNITY;
            end else if (hit) begin
                if (cfg_sel == SEL_OFFSET) sh_off_q  <= cfg_wdata[OFS_W-1:0];
                else                       sh_gain_q <= cfg_wdata;
            end
        end

        // Move the shadow fields into the working set on a frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_off[c*OFS_W +: OFS_W]    <= '0;
                act_gain[c*GAIN_W +: GAIN_W] <= GAIN_UNITY;
            end else if (frame_sync) begin
                act_off[c*OFS_W +: OFS_W]    <= sh_off_q;
                act_gain[c*GAIN_W +: GAIN_W] <= sh_gain_q;
            end
        end
    end

    // R8
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> ($stable(act_off) && $stable(act_gain)));
endmodule

// File: rtl/tiadc_lane_corr.sv
// One channel's correction path.
// Stage 1 forms (x*2^OFB + off) * gain using the coefficients present at capture.
// Stage 2 rounds half-up, shifts out the fraction and saturates to SW bits.
// Assumes OFS_W <= SW + OFB.
module tiadc_lane_corr
    import tiadc_pkg::*;
#(
    parameter int SW    = 8,
    parameter int OFS_W = 8,
    parameter int OFB   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap1,
    input  logic              cap2,
    input  logic [SW-1:0]     x,
    input  logic [OFS_W-1:0]  off,
    input  logic [GAIN_W-1:0] gain,
    output logic [SW-1:0]     y
);
    localparam int AW = SW + OFB + 1;
    localparam int PW = AW + GAIN_W + 1;
    localparam int SH = GAIN_FRAC + OFB;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (SH - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (SW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = ~MAXV;

    logic signed [AW-1:0] x_ext, off_ext, sum_c;
    logic signed [PW-1:0] prod_c, prod_q, rnd_c;
    logic                 sat_hi_c, sat_lo_c;
    logic [SW-1:0]        y_c;

    // Scale the sample to the offset grid, add the trim, apply the gain.
    always_comb begin
        x_ext   = {{(AW-SW){x[SW-1]}}, x};
        off_ext = {{(AW-OFS_W){off[OFS_W-1]}}, off};
        sum_c   = (x_ext <<< OFB) + off_ext;
        prod_c  = PW'(sum_c) * PW'($signed({1'b0, gain}));
    end

    // Hold the full-precision product of the captured sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    prod_q <= '0;
        else if (cap1) prod_q <= prod_c;
    end

    // Round half-up, drop the fraction and clamp to the sample range.
    always_comb begin
        rnd_c    = (prod_q + HALF) >>> SH;
        sat_hi_c = rnd_c > MAXV;
        sat_lo_c = rnd_c < MINV;
        if (sat_hi_c)      y_c = MAXV[SW-1:0];
        else if (sat_lo_c) y_c = MINV[SW-1:0];
        else               y_c = rnd_c[SW-1:0];
    end

    // Register the corrected sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    y <= '0;
        else if (cap2) y <= y_c;
    end

    // R7
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap2 && sat_hi_c) |=> (y == MAXV[SW-1:0]));
    // R7
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap2 && sat_lo_c) |=> (y == MINV[SW-1:0]));
endmodule

// File: rtl/tiadc_serializer.sv
// Replays each corrected word one lane per clock, lane 0 (earliest phase) first.
// A newer word restarts the replay at lane 0. Assumes NCH >= 2.
module tiadc_serializer #(
    parameter int NCH  = 4,
    parameter int SW   = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [NCH*SW-1:0] word,
    output logic              ser_valid,
    output logic [SW-1:0]     ser_data,
    output logic [CHW-1:0]    ser_lane
);
    localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

    logic [NCH*SW-1:0] hold_q;
    logic [CHW-1:0]    nxt_lane;

    assign nxt_lane = ser_lane + CHW'(1);

    // Load a new word or step to the next lane of the held word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            ser_valid <= 1'b0;
            ser_data  <= '0;
            ser_lane  <= '0;
        end else if (word_valid) begin
            hold_q    <= word;
            ser_valid <= 1'b1;
            ser_data  <= word[SW-1:0];
            ser_lane  <= '0;
        end else if (ser_valid && ser_lane != LAST) begin
            ser_data  <= hold_q[nxt_lane*SW +: SW];
            ser_lane  <= nxt_lane;
        end else begin
            ser_valid <= 1'b0;
        end
    end

    // R10
    ser_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> (ser_valid && ser_lane == '0));
    // R10
    ser_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !word_valid && ser_lane != LAST) |=>
        (ser_valid && ser_lane == $past(ser_lane) + CHW'(1)));
endmodule

// File: rtl/tiadc_combiner.sv
// Top of the interleaved-converter combiner.
// Corrects each channel with its own offset and gain, keeps lanes in phase order,
// and offers a serial replay. Assumes NCH is a power of two, at least 2.
module tiadc_combiner
    import tiadc_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int SW    = 8,
    parameter int OFS_W = 8,
    parameter int OFB   = 3,
    localparam int CHW  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [NCH*SW-1:0] in_data,
    input  logic              frame_sync,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic              cfg_sel,
    input  logic [GAIN_W-1:0] cfg_wdata,
    output logic              out_valid,
    output logic [NCH*SW-1:0] out_data,
    output logic              ser_valid,
    output logic [SW-1:0]     ser_data,
    output logic [CHW-1:0]    ser_lane
);
    logic [NCH*OFS_W-1:0]  act_off;
    logic [NCH*GAIN_W-1:0] act_gain;
    logic                  v1_q;

    tiadc_coef_bank #(.NCH(NCH), .OFS_W(OFS_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_ch     (cfg_ch),
        .cfg_sel    (coef_sel_e'(cfg_sel)),
        .cfg_wdata  (cfg_wdata),
        .frame_sync (frame_sync),
        .act_off    (act_off),
        .act_gain   (act_gain)
    );

    // Carry the shared valid through both correction stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1_q      <= in_valid;
            out_valid <= v1_q;
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        tiadc_lane_corr #(.SW(SW), .OFS_W(OFS_W), .OFB(OFB)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .cap1  (in_valid),
            .cap2  (v1_q),
            .x     (in_data[k*SW +: SW]),
            .off   (act_off[k*OFS_W +: OFS_W]),
            .gain  (act_gain[k*GAIN_W +: GAIN_W]),
            .y     (out_data[k*SW +: SW])
        );
    end

    tiadc_serializer #(.NCH(NCH), .SW(SW)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (out_valid),
        .word       (out_data),
        .ser_valid  (ser_valid),
        .ser_data   (ser_data),
        .ser_lane   (ser_lane)
    );

    // R3
    lat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    // R3
    lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);
endmodule

// File: tb/tb_tiadc_combiner.sv
module tb_tiadc_combiner;
    localparam int NCH = 4;
    localparam int SW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [NCH*SW-1:0] in_data = '0;
    logic              frame_sync = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_ch = '0;
    logic              cfg_sel = 1'b0;
    logic [15:0]       cfg_wdata = '0;
    logic              out_valid, ser_valid;
    logic [NCH*SW-1:0] out_data;
    logic [SW-1:0]     ser_data;
    logic [1:0]        ser_lane;

    tiadc_combiner dut (.*);

    always #4 clk = ~clk;

    int    n_chk = 0, n_fail = 0;
    bit    chk_en = 1'b0, done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int sh_off[NCH], sh_gain[NCH], ac_off[NCH], ac_gain[NCH];
    int p1w[NCH], ow[NCH], sbuf[NCH];
    bit p1v, ov, sv;
    int slane;

    function automatic int corr(int x, int off, int g);
        longint v = longint'(x) * 8 + off;
        longint r = (v * g + (64'sd1 <<< 17)) >>> 18;
        if (r > 127) r = 127;
        if (r < -128) r = -128;
        return int'(r);
    endfunction

    // behavioural model, updated on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            p1v = 0; ov = 0; sv = 0; slane = 0;
            for (int k = 0; k < NCH; k++) begin
                sh_off[k] = 0; ac_off[k] = 0; sh_gain[k] = 32768; ac_gain[k] = 32768;
                p1w[k] = 0; ow[k] = 0; sbuf[k] = 0;
            end
        end else begin
            if (ov) begin
                for (int k = 0; k < NCH; k++) sbuf[k] = ow[k];
                sv = 1; slane = 0;
            end else if (sv && slane < NCH-1) slane++;
            else sv = 0;
            if (p1v) for (int k = 0; k < NCH; k++) ow[k] = p1w[k];
            ov = p1v;
            if (in_valid)
                for (int k = 0; k < NCH; k++)
                    p1w[k] = corr(int'(signed'(in_data[k*SW +: SW])), ac_off[k], ac_gain[k]);
            p1v = in_valid;
            if (frame_sync)
                for (int k = 0; k < NCH; k++) begin ac_off[k] = sh_off[k]; ac_gain[k] = sh_gain[k]; end
            if (cfg_we) begin
                if (cfg_sel) sh_gain[cfg_ch] = int'(cfg_wdata);
                else         sh_off[cfg_ch]  = int'(signed'(cfg_wdata[7:0]));
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // compare outputs against the model between edges
    always @(negedge clk) if (chk_en) begin
        chk("out_valid", int'(out_valid), int'(ov));
        if (ov) for (int k = 0; k < NCH; k++)
            chk($sformatf("lane%0d", k), int'(signed'(out_data[k*SW +: SW])), ow[k]);
        chk("ser_valid", int'(ser_valid), int'(sv));
        if (sv) begin
            chk("ser_lane", int'(ser_lane), slane);
            chk("ser_data", int'(signed'(ser_data)), sbuf[slane]);
        end
    end

    function automatic logic [NCH*SW-1:0] pk(int a, int b, int c, int d);
        return {8'(d), 8'(c), 8'(b), 8'(a)};
    endfunction

    task automatic step(bit v, logic [NCH*SW-1:0] d, bit fs);
        @(negedge clk);
        in_valid = v; in_data = d; frame_sync = fs; cfg_we = 0;
    endtask

    task automatic wr(int ch, bit sel, int val, bit fs);
        @(negedge clk);
        in_valid = 0; frame_sync = fs; cfg_we = 1;
        cfg_ch = 2'(ch); cfg_sel = sel; cfg_wdata = 16'(val);
    endtask

    task automatic idle(int n);
        repeat (n) step(0, in_data, 0);
    endtask

    task automatic word(int a, int b, int c, int d);
        step(1, pk(a, b, c, d), 0);
        idle(NCH + 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf = 32'h1234_5678;
        repeat (3) @(posedge clk);
        chk_en = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 out_data zero", int'(out_data), 0);
        rst_n = 1;
        idle(2);

        cur_req = "R2";
        word(1, 2, 3, 4); word(-128, 127, -1, 0); word(55, -77, 100, -3);
        cur_req = "R3";
        for (int i = 0; i < 6; i++) step(1, pk(i, -i, 10*i, -10*i), 0);
        idle(NCH + 2);

        cur_req = "R8";
        wr(0, 0, 8, 0); wr(1, 1, 16'h4000, 0);
        word(10, 10, 10, 10);                 // no commit yet: unchanged
        step(1, pk(20, 20, 20, 20), 1);       // same edge as commit: old set
        wr(2, 0, 16, 1);                      // write in commit cycle waits
        word(20, 20, 20, 20);
        step(0, in_data, 1); idle(1);
        word(20, 20, 20, 20);

        cur_req = "R4";
        wr(0, 0, 4, 0); wr(1, 0, -3, 0); wr(2, 0, -4, 0); wr(3, 0, 12, 0);
        wr(1, 1, 16'h8000, 1); idle(1);
        word(5, 5, 5, 5); word(-5, -5, -5, -5);
        cur_req = "R6";
        word(0, -1, -1, 0); word(-7, 6, -6, 3);

        cur_req = "R5";
        wr(0, 1, 16'h4000, 0); wr(1, 1, 16'hC000, 0); wr(2, 1, 16'hFFFF, 0); wr(3, 1, 16'h0000, 0);
        for (int k = 0; k < NCH; k++) wr(k, 0, 0, 0);
        step(0, in_data, 1); idle(1);
        word(3, 3, 3, 3); word(-3, 51, -51, 99);

        cur_req = "R7";
        word(127, 127, 127, 127); word(-128, -128, -128, -128); word(-128, 90, -90, 0);

        cur_req = "R9";
        for (int k = 0; k < NCH; k++) begin wr(k, 1, 16'h8000, 0); wr(k, 0, 127, 0); end
        step(1, pk(1, 2, 3, 4), 1);
        word(127, -128, 0, 1);
        cur_req = "R11";
        for (int k = 0; k < NCH; k++) wr(k, 0, 0, 0);
        wr(2, 1, 16'h2000, 1); idle(1);
        word(40, 40, 40, 40);

        cur_req = "R10";
        step(1, pk(9, 8, 7, 6), 0); idle(2);
        step(1, pk(-9, -8, -7, -6), 0); idle(NCH + 2);

        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            if (lf[3:0] == 4'd0) wr(int'(lf[9:8]), lf[10], int'(lf[31:16]), lf[11]);
            else step(lf[4] | lf[5], lf, lf[7:4] == 4'd5);
        end
        idle(NCH + 2);

        cur_req = "R1";
        step(1, pk(1, 1, 1, 1), 0);
        @(negedge clk); rst_n = 0; in_valid = 0;
        idle(2);
        rst_n = 1;
        idle(1);
        cur_req = "R2";
        word(33, -33, 66, -66);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule